// File: doc/BRIEF.md
# Hypervisor Status Control Register with Guest Intercepts

This block holds the 64-bit status register that a hypervisor uses to steer one guest. It sits beside the CSR file of a core that runs in five modes: user, hypervisor-supervisor (HS), machine, virtual user (VU) and virtual supervisor (VS). The pipeline reads and writes it through a simple CSR strobe interface. Writes are legalized per field, so an illegal value in a field leaves that field unchanged. The register also follows the virtualization state across traps into HS-mode and across an SRET executed in HS-mode.

Each cycle the block also looks at the operation the pipeline is about to retire and at the current mode. From that and the register's trap-enable bits it raises a virtual-instruction exception or an illegal-instruction exception. It drives the guest's register width, its byte order and the selected guest interrupt line straight to the rest of the core. The pipeline, address translation and the interrupt controller are outside this block.

Top module: `virt_status_reg`

## Requirements
- R1: A CSR access with `csrValid` high and `csrAddr` = 0x600 from HS (mode code 1) or M (code 3) returns the register on `csrRdata` in the same cycle. Any other address gives `csrRdata` = 0 and `csrFault` = 0.
- R2: An access to 0x600 from U (code 0), VU (code 4) or VS (code 5) sets `csrFault` in that cycle and drives `csrRdata` to 0. A write made this way changes nothing.
- R3: Bits 63:34 and 4:0 always read as zero. Writing ones to them has no visible effect.
- R4: Bits 33:32 hold the guest width and appear on `guestXlen`. 1 means 32-bit and 2 means 64-bit. A write of 0 or 3 keeps the previous value.
- R5: Bits 17:12 hold the guest interrupt select and appear on `guestIrqSel`. A written value above the parameter `GEILEN` (default 8) keeps the previous select. `guestIrqValid` is high exactly when the select is between 1 and `GEILEN`.
- R6: These single bits are freely writable and read back as written: bit 22 (trap guest SRET), bit 21 (trap guest WFI), bit 20 (trap guest translation ops), bit 9 (user hypervisor load/store allowed), bit 8 (previous guest privilege), bit 7 (previous virtualization), bit 6 (guest virtual address flag) and bit 5 (guest big-endian, also shown on `guestBigEndian`).
- R7: In VS-mode, with bit 22 set, `opCode` 1 (SRET) raises `virtInstrExc` in the same cycle.
- R8: In VS-mode, with bit 21 set, `opCode` 2 (WFI) raises `virtInstrExc` at once, which is a wait bound of zero.
- R9: In VS-mode, with bit 20 set, `opCode` 3 (satp access), 4 (SFENCE.VMA) or 5 (SINVAL.VMA) raises `virtInstrExc`. No other mode or opcode raises it.
- R10: In U-mode with bit 9 clear, `opCode` 6 (hypervisor load/store) raises `illegalInstrExc`. With bit 9 set it does not. The two exception outputs are never high together.
- R11: On `trapEnter`, the next cycle bit 7 holds the prior V (1 for VS or VU) and bit 6 holds `trapGva`. Bit 8 takes 1 if the prior mode was VS and 0 if it was VU. It is left unchanged when V was 0.
- R12: While `opCode` is 1 in HS-mode, `sretNextVirt` shows bit 7. Bit 7 is cleared in the next cycle.
- R13: Priority in one cycle is trap update first, then HS SRET, then CSR write. A write in the same cycle as either of the other two is dropped.
- R14: After reset the register reads 0x0000_0002_0000_0000, so the guest width is 64-bit and every other field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | CSR access this cycle |
| csrWrite | input | 1 | Access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Read data, zero unless a permitted hit |
| csrFault | output | 1 | Access from an unprivileged mode |
| curMode | input | 3 | Current mode: 0 U, 1 HS, 3 M, 4 VU, 5 VS |
| opCode | input | 3 | Guarded operation: 0 none, 1 SRET, 2 WFI, 3 satp, 4 SFENCE.VMA, 5 SINVAL.VMA, 6 hyp load/store |
| trapEnter | input | 1 | A trap into HS-mode is taken this cycle |
| trapGva | input | 1 | Trap value is a guest virtual address |
| virtInstrExc | output | 1 | Virtual-instruction exception |
| illegalInstrExc | output | 1 | Illegal-instruction exception |
| sretNextVirt | output | 1 | V to restore on an HS SRET |
| guestXlen | output | 2 | Guest width code |
| guestBigEndian | output | 1 | Guest accesses are big-endian |
| guestIrqSel | output | 6 | Selected guest interrupt index |
| guestIrqValid | output | 1 | Select names an implemented source |

## Verification
The bench writes the reserved width codes 0 and 3 and interrupt selects just above and at `GEILEN`. A design that accepted them would read back a width code the guest cannot use, or a select with no source behind it. It collides a trap with a CSR write, and an HS SRET with a write. Wrong priority shows up as the written value surviving over the captured virtualization bits. It also takes traps from HS, VU and VS, because a design that always loads the previous-privilege bit would break the HS case. Finally, it sends each guarded operation from every mode with the enable bits on and off. Intercepts that leak into VU, HS or U would raise exceptions the model does not expect.

// File: rtl/vstat_pkg.sv
package vstat_pkg;

  localparam logic [11:0] CSR_ADDR_STATUS = 12'h600;
  localparam int IRQ_W = 6;

  localparam int POS_XLEN = 32;
  localparam int POS_TSR  = 22;
  localparam int POS_TW   = 21;
  localparam int POS_TVM  = 20;
  localparam int POS_IRQ  = 12;
  localparam int POS_HU   = 9;
  localparam int POS_SPVP = 8;
  localparam int POS_SPV  = 7;
  localparam int POS_GVA  = 6;
  localparam int POS_BE   = 5;

  typedef enum logic [2:0] {
    MODE_U  = 3'd0,
    MODE_HS = 3'd1,
    MODE_M  = 3'd3,
    MODE_VU = 3'd4,
    MODE_VS = 3'd5
  } privMode_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SRET   = 3'd1,
    OP_WFI    = 3'd2,
    OP_SATP   = 3'd3,
    OP_SFENCE = 3'd4,
    OP_SINVAL = 3'd5,
    OP_HLS    = 3'd6
  } guardOp_e;

  typedef struct packed {
    logic wrEn;
    logic trapEn;
    logic trapVirt;
    logic trapPriv;
    logic trapGva;
    logic sretEn;
  } strobes_t;

endpackage

// File: rtl/vstat_ctrl.sv
module vstat_ctrl
  import vstat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csrValid,
  input  logic       csrWrite,
  input  logic [11:0] csrAddr,
  input  logic [2:0] curMode,
  input  logic [2:0] opCode,
  input  logic       trapEnter,
  input  logic       trapGva,
  output strobes_t   stb,
  output logic       rdEn,
  output logic       accFault
);

  logic addrHit;
  logic privOk;
  logic inVirt;

  assign addrHit  = csrValid && (csrAddr == CSR_ADDR_STATUS);
  assign privOk   = (curMode == MODE_HS) || (curMode == MODE_M);
  assign inVirt   = (curMode == MODE_VU) || (curMode == MODE_VS);

  assign rdEn     = addrHit && privOk;
  assign accFault = addrHit && !privOk;

  always_comb begin
    stb          = '0;
    stb.trapEn   = trapEnter;
    stb.trapVirt = inVirt;
    stb.trapPriv = (curMode == MODE_VS);
    stb.trapGva  = trapGva;
    stb.sretEn   = (opCode == OP_SRET) && (curMode == MODE_HS);
    stb.wrEn     = rdEn && csrWrite;
  end

  // R2: a faulting access never turns into a write strobe
  assert_fault_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    accFault |-> !stb.wrEn);

endmodule

// File: rtl/vstat_intercept.sv
module vstat_intercept
  import vstat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] curMode,
  input  logic [2:0] opCode,
  input  logic       trapSret,
  input  logic       trapWfi,
  input  logic       trapVm,
  input  logic       userHypOk,
  output logic       virtExc,
  output logic       illegalExc
);

  logic inVs;
  logic inUser;
  logic vmOp;

  assign inVs   = (curMode == MODE_VS);
  assign inUser = (curMode == MODE_U);
  assign vmOp   = (opCode == OP_SATP) || (opCode == OP_SFENCE) || (opCode == OP_SINVAL);

  always_comb begin
    virtExc = 1'b0;
    if (inVs) begin
      if (opCode == OP_SRET && trapSret) virtExc = 1'b1;
      if (opCode == OP_WFI && trapWfi)   virtExc = 1'b1;
      if (vmOp && trapVm)                virtExc = 1'b1;
    end
  end

  assign illegalExc = inUser && (opCode == OP_HLS) && !userHypOk;

  // R10: the two exception kinds are exclusive
  assert_exc_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({virtExc, illegalExc}));

  // R9: virtual-instruction exceptions come only from VS-mode
  assert_virt_only_vs_R9: assert property (@(posedge clk) disable iff (!rstN)
    virtExc |-> inVs);

endmodule

// File: rtl/vstat_dp.sv
module vstat_dp
  import vstat_pkg::*;
#(
  parameter int GEILEN = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [63:0]       wdata,
  output logic [63:0]       readValue,
  output logic [1:0]        xlenCode,
  output logic              trapSret,
  output logic              trapWfi,
  output logic              trapVm,
  output logic [IRQ_W-1:0]  irqSel,
  output logic              userHypOk,
  output logic              prevPriv,
  output logic              prevVirt,
  output logic              gvaFlag,
  output logic              bigEndian
);

  localparam logic [IRQ_W-1:0] IRQ_MAX = IRQ_W'(GEILEN);
  localparam logic [1:0] XLEN_RESET = 2'd2;

  logic [1:0]       xlenQ;
  logic             tsrQ, twQ, tvmQ, huQ, spvpQ, spvQ, gvaQ, beQ;
  logic [IRQ_W-1:0] irqQ;

  logic [1:0]       wrXlen;
  logic [IRQ_W-1:0] wrIrq;
  logic             xlenLegal;
  logic             irqLegal;

  assign wrXlen    = wdata[POS_XLEN+1:POS_XLEN];
  assign wrIrq     = wdata[POS_IRQ+IRQ_W-1:POS_IRQ];
  assign xlenLegal = (wrXlen == 2'd1) || (wrXlen == 2'd2);
  assign irqLegal  = (wrIrq <= IRQ_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlenQ <= XLEN_RESET;
      tsrQ  <= 1'b0;
      twQ   <= 1'b0;
      tvmQ  <= 1'b0;
      irqQ  <= '0;
      huQ   <= 1'b0;
      spvpQ <= 1'b0;
      spvQ  <= 1'b0;
      gvaQ  <= 1'b0;
      beQ   <= 1'b0;
    end else if (stb.trapEn) begin
      spvQ <= stb.trapVirt;
      gvaQ <= stb.trapGva;
      if (stb.trapVirt) spvpQ <= stb.trapPriv;
    end else if (stb.sretEn) begin
      spvQ <= 1'b0;
    end else if (stb.wrEn) begin
      if (xlenLegal) xlenQ <= wrXlen;
      if (irqLegal)  irqQ  <= wrIrq;
      tsrQ  <= wdata[POS_TSR];
      twQ   <= wdata[POS_TW];
      tvmQ  <= wdata[POS_TVM];
      huQ   <= wdata[POS_HU];
      spvpQ <= wdata[POS_SPVP];
      spvQ  <= wdata[POS_SPV];
      gvaQ  <= wdata[POS_GVA];
      beQ   <= wdata[POS_BE];
    end
  end

  always_comb begin
    readValue = '0;
    readValue[POS_XLEN+1:POS_XLEN]      = xlenQ;
    readValue[POS_TSR]                  = tsrQ;
    readValue[POS_TW]                   = twQ;
    readValue[POS_TVM]                  = tvmQ;
    readValue[POS_IRQ+IRQ_W-1:POS_IRQ]  = irqQ;
    readValue[POS_HU]                   = huQ;
    readValue[POS_SPVP]                 = spvpQ;
    readValue[POS_SPV]                  = spvQ;
    readValue[POS_GVA]                  = gvaQ;
    readValue[POS_BE]                   = beQ;
  end

  assign xlenCode  = xlenQ;
  assign trapSret  = tsrQ;
  assign trapWfi   = twQ;
  assign trapVm    = tvmQ;
  assign irqSel    = irqQ;
  assign userHypOk = huQ;
  assign prevPriv  = spvpQ;
  assign prevVirt  = spvQ;
  assign gvaFlag   = gvaQ;
  assign bigEndian = beQ;

  // R4: the width field never holds a reserved code
  assert_xlen_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xlenQ == 2'd1) || (xlenQ == 2'd2));

  // R5: the interrupt select never exceeds the implemented count
  assert_irq_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqQ <= IRQ_MAX);

  // R11: a trap captures the prior virtualization state and the address flag
  assert_trap_capture_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.trapEn |=> (spvQ == $past(stb.trapVirt)) && (gvaQ == $past(stb.trapGva)));

  // R11: a trap from a non-virtual mode leaves the previous privilege alone
  assert_trap_keep_priv_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.trapEn && !stb.trapVirt) |=> $stable(spvpQ));

  // R12: HS return without a trap clears the saved virtualization bit
  assert_sret_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sretEn && !stb.trapEn) |=> !spvQ);

endmodule

// File: rtl/virt_status_reg.sv
module virt_status_reg
  import vstat_pkg::*;
#(
  parameter int GEILEN = 8
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrValid,
  input  logic        csrWrite,
  input  logic [11:0] csrAddr,
  input  logic [63:0] csrWdata,
  output logic [63:0] csrRdata,
  output logic        csrFault,
  input  logic [2:0]  curMode,
  input  logic [2:0]  opCode,
  input  logic        trapEnter,
  input  logic        trapGva,
  output logic        virtInstrExc,
  output logic        illegalInstrExc,
  output logic        sretNextVirt,
  output logic [1:0]  guestXlen,
  output logic        guestBigEndian,
  output logic [5:0]  guestIrqSel,
  output logic        guestIrqValid
);

  localparam logic [IRQ_W-1:0] IRQ_MAX = IRQ_W'(GEILEN);

  strobes_t         stb;
  logic             rdEn;
  logic [63:0]      readValue;
  logic             trapSret, trapWfi, trapVm, userHypOk;
  logic             prevPriv, prevVirt, gvaFlag;
  logic [IRQ_W-1:0] irqSel;

  vstat_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csrValid  (csrValid),
    .csrWrite  (csrWrite),
    .csrAddr   (csrAddr),
    .curMode   (curMode),
    .opCode    (opCode),
    .trapEnter (trapEnter),
    .trapGva   (trapGva),
    .stb       (stb),
    .rdEn      (rdEn),
    .accFault  (csrFault)
  );

  vstat_dp #(.GEILEN(GEILEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (csrWdata),
    .readValue (readValue),
    .xlenCode  (guestXlen),
    .trapSret  (trapSret),
    .trapWfi   (trapWfi),
    .trapVm    (trapVm),
    .irqSel    (irqSel),
    .userHypOk (userHypOk),
    .prevPriv  (prevPriv),
    .prevVirt  (prevVirt),
    .gvaFlag   (gvaFlag),
    .bigEndian (guestBigEndian)
  );

  vstat_intercept u_icpt (
    .clk        (clk),
    .rstN       (rstN),
    .curMode    (curMode),
    .opCode     (opCode),
    .trapSret   (trapSret),
    .trapWfi    (trapWfi),
    .trapVm     (trapVm),
    .userHypOk  (userHypOk),
    .virtExc    (virtInstrExc),
    .illegalExc (illegalInstrExc)
  );

  assign csrRdata      = rdEn ? readValue : 64'd0;
  assign sretNextVirt  = prevVirt;
  assign guestIrqSel   = irqSel;
  assign guestIrqValid = (irqSel != '0) && (irqSel <= IRQ_MAX);

  // R3: reserved ranges read as zero
  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csrRdata[63:34] == '0) && (csrRdata[4:0] == '0));

  // R2: a faulting access returns no data
  assert_fault_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    csrFault |-> (csrRdata == 64'd0));

  // R13: a write beside a trap leaves the flag bit to the trap
  assert_trap_wins_R13: assert property (@(posedge clk) disable iff (!rstN)
    (trapEnter && csrValid && csrWrite) |=> (prevVirt == $past(curMode == MODE_VU || curMode == MODE_VS))
      && (gvaFlag == $past(trapGva)));

  // R11: on a trap from VS the previous privilege becomes VS
  assert_trap_vs_priv_R11: assert property (@(posedge clk) disable iff (!rstN)
    (trapEnter && curMode == MODE_VS) |=> prevPriv);

endmodule

// File: tb/test_virt_status_reg.sv
module test_virt_status_reg;

  localparam int GEILEN = 8;

  logic        clk = 1'b0;
  logic        rstN;
  logic        csrValid, csrWrite;
  logic [11:0] csrAddr;
  logic [63:0] csrWdata;
  logic [63:0] csrRdata;
  logic        csrFault;
  logic [2:0]  curMode, opCode;
  logic        trapEnter, trapGva;
  logic        virtInstrExc, illegalInstrExc, sretNextVirt;
  logic [1:0]  guestXlen;
  logic        guestBigEndian;
  logic [5:0]  guestIrqSel;
  logic        guestIrqValid;

  always #10 clk = ~clk;

  virt_status_reg #(.GEILEN(GEILEN)) i_virt_status_reg (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata), .csrFault(csrFault),
    .curMode(curMode), .opCode(opCode), .trapEnter(trapEnter), .trapGva(trapGva),
    .virtInstrExc(virtInstrExc), .illegalInstrExc(illegalInstrExc),
    .sretNextVirt(sretNextVirt), .guestXlen(guestXlen), .guestBigEndian(guestBigEndian),
    .guestIrqSel(guestIrqSel), .guestIrqValid(guestIrqValid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R14";

  // reference state, one variable per field
  int mXlen, mIrq;
  bit mTsr, mTw, mTvm, mHu, mSpvp, mSpv, mGva, mBe;

  function automatic logic [63:0] modelRead();
    logic [63:0] v = '0;
    v[33:32] = 2'(mXlen);
    v[22] = mTsr; v[21] = mTw; v[20] = mTvm;
    v[17:12] = 6'(mIrq);
    v[9] = mHu; v[8] = mSpvp; v[7] = mSpv; v[6] = mGva; v[5] = mBe;
    return v;
  endfunction

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", curReq, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, int addr, logic [63:0] wd, int mode, int op, bit tr, bit gva);
    bit hit, priv, vmOp, expVirt, expIll;
    logic [63:0] expRd;
    int nx, ni;
    @(negedge clk);
    csrValid = v; csrWrite = w; csrAddr = 12'(addr); csrWdata = wd;
    curMode = 3'(mode); opCode = 3'(op); trapEnter = tr; trapGva = gva;
    #5;
    hit  = v && (addr == 'h600);
    priv = (mode == 1) || (mode == 3);
    expRd = (hit && priv) ? modelRead() : 64'd0;
    vmOp = (op == 3) || (op == 4) || (op == 5);
    expVirt = (mode == 5) && ((op == 1 && mTsr) || (op == 2 && mTw) || (vmOp && mTvm));
    expIll  = (mode == 0) && (op == 6) && !mHu;
    check("csrRdata", csrRdata, expRd);
    check("csrFault", 64'(csrFault), 64'(hit && !priv));
    check("virtInstrExc", 64'(virtInstrExc), 64'(expVirt));
    check("illegalInstrExc", 64'(illegalInstrExc), 64'(expIll));
    check("sretNextVirt", 64'(sretNextVirt), 64'(mSpv));
    check("guestXlen", 64'(guestXlen), 64'(mXlen));
    check("guestBigEndian", 64'(guestBigEndian), 64'(mBe));
    check("guestIrqSel", 64'(guestIrqSel), 64'(mIrq));
    check("guestIrqValid", 64'(guestIrqValid), 64'(mIrq >= 1 && mIrq <= GEILEN));
    @(posedge clk);
    if (tr) begin
      mSpv = (mode == 4) || (mode == 5);
      mGva = gva;
      if (mSpv) mSpvp = (mode == 5);
    end else if (op == 1 && mode == 1) begin
      mSpv = 0;
    end else if (hit && priv && w) begin
      nx = int'(wd[33:32]);
      if (nx == 1 || nx == 2) mXlen = nx;
      ni = int'(wd[17:12]);
      if (ni <= GEILEN) mIrq = ni;
      mTsr = wd[22]; mTw = wd[21]; mTvm = wd[20]; mHu = wd[9];
      mSpvp = wd[8]; mSpv = wd[7]; mGva = wd[6]; mBe = wd[5];
    end
  endtask

  task automatic rd(int mode);
    step(1, 0, 'h600, 64'd0, mode, 0, 0, 0);
  endtask

  task automatic wr(int mode, logic [63:0] wd);
    step(1, 1, 'h600, wd, mode, 0, 0, 0);
  endtask

  function automatic int pickMode(int r);
    case (r % 5)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 4;
      default: return 5;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL all watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; csrValid = 0; csrWrite = 0; csrAddr = '0; csrWdata = '0;
    curMode = 3'd1; opCode = 3'd0; trapEnter = 0; trapGva = 0;
    mXlen = 2; mIrq = 0;
    {mTsr, mTw, mTvm, mHu, mSpvp, mSpv, mGva, mBe} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    curReq = "R14"; rd(1);
    curReq = "R1";  rd(3); step(1, 0, 'h601, 64'd0, 1, 0, 0, 0); step(0, 0, 'h600, 64'd0, 3, 0, 0, 0);
    curReq = "R3";  wr(1, '1); rd(1);
    curReq = "R6";  wr(3, 64'h0000_0001_0070_53E0); rd(1); wr(1, 64'h0000_0002_0000_0140); rd(3);
    curReq = "R4";  wr(1, 64'h0000_0000_0000_0000); rd(1); wr(1, 64'h0000_0003_0000_0000); rd(1);
                    wr(1, 64'h0000_0001_0000_0000); rd(1); wr(1, 64'h0000_0002_0000_0000); rd(1);
    curReq = "R5";  wr(1, 64'h0000_0002_0000_8000); rd(1); wr(1, 64'h0000_0002_0000_9000); rd(1);
                    wr(1, 64'h0000_0002_0000_1000); rd(1); wr(1, 64'h0000_0002_0000_F000); rd(1);
                    wr(1, 64'h0000_0002_0000_0000); rd(1);
    curReq = "R2";  wr(1, 64'h0000_0002_0000_3020);
                    step(1, 1, 'h600, 64'h0000_0001_0070_0000, 5, 0, 0, 0);
                    step(1, 1, 'h600, 64'h0000_0001_0070_0000, 4, 0, 0, 0);
                    step(1, 1, 'h600, 64'h0000_0001_0070_0000, 0, 0, 0, 0); rd(1);
    curReq = "R7";  wr(1, 64'h0000_0002_0040_0000);
                    for (int m = 0; m < 5; m++) step(0, 0, 0, 0, pickMode(m), 1, 0, 0);
    curReq = "R8";  wr(1, 64'h0000_0002_0020_0000);
                    for (int m = 0; m < 5; m++) step(0, 0, 0, 0, pickMode(m), 2, 0, 0);
                    step(0, 0, 0, 0, 5, 1, 0, 0);
    curReq = "R9";  wr(1, 64'h0000_0002_0010_0000);
                    for (int o = 0; o < 7; o++) begin step(0, 0, 0, 0, 5, o, 0, 0); step(0, 0, 0, 0, 4, o, 0, 0); end
                    wr(1, 64'h0000_0002_0000_0000);
                    for (int o = 0; o < 7; o++) step(0, 0, 0, 0, 5, o, 0, 0);
    curReq = "R10"; step(0, 0, 0, 0, 0, 6, 0, 0); step(0, 0, 0, 0, 1, 6, 0, 0);
                    wr(1, 64'h0000_0002_0000_0200); step(0, 0, 0, 0, 0, 6, 0, 0);
    curReq = "R11"; wr(1, 64'h0000_0002_0000_0000);
                    step(0, 0, 0, 0, 5, 0, 1, 1); rd(1);
                    step(0, 0, 0, 0, 1, 0, 1, 0); rd(1);
                    step(0, 0, 0, 0, 4, 0, 1, 1); rd(1);
                    step(0, 0, 0, 0, 5, 0, 1, 0); step(0, 0, 0, 0, 0, 0, 1, 1); rd(1);
    curReq = "R12"; step(0, 0, 0, 0, 4, 0, 1, 0); step(0, 0, 0, 0, 1, 1, 0, 0); rd(1);
                    step(0, 0, 0, 0, 5, 1, 0, 0); rd(1);
    curReq = "R13"; step(1, 1, 'h600, 64'h0000_0001_0000_01E0, 4, 0, 1, 0); rd(1);
                    step(1, 1, 'h600, 64'h0000_0001_0000_01E0, 1, 0, 1, 0); rd(1);
                    wr(1, 64'h0000_0002_0000_0080);
                    step(1, 1, 'h600, 64'h0000_0001_0070_00A0, 1, 1, 0, 0); rd(1);

    curReq = "R1/R13 mixed";
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom);
      int md = pickMode(r >> 3);
      logic [63:0] wd = {$urandom, $urandom};
      step((r & 1) == 1, (r & 2) == 2, ((r & 'h60) == 0) ? 'h601 : 'h600, wd,
           md, (r >> 8) % 7, ((r >> 12) % 9) == 0, (r & 'h4000) != 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule